// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It walks a two-level page table held in memory. A requester offers one translation at a time over a valid/ready handshake. Along with the address, the requester supplies the access kind, the current privilege and four status controls: supervisor-may-touch-user-pages, execute-implies-readable, modify-privilege and the previous-privilege field. The walker fetches page table entries (PTEs) over a simple memory port whose responses may flag an error. It applies the full validity, privilege, alignment and permission checks to the leaf entry. If the accessed or dirty flag must change, it writes the entry back. It then reports either a fault or the physical address with read, write and execute grants.

The requester uses the result to fill its own translation cache. The block keeps no cached entries, and it does no physical-region protection checks.

Top module: `pt2_walker`

## Requirements
- R1: `reqReady` is high only while the walker is idle. A request is taken on a cycle with `reqValid` and `reqReady` both high. Each accepted request produces exactly one result, shown by `rspValid` high for a single cycle.
- R2: The effective privilege is `reqMpp` when `reqPriv` is 3 (machine), `reqMprv` is 1 and the access is a load or store. In every other case it is `reqPriv`. An effective privilege of machine returns the zero-extended virtual address with read, write and execute all granted, and makes no memory access. Encodings: privilege 0 = user, 1 = supervisor, 3 = machine; `reqAccess` 0 = fetch, 1 = load, 2 = store.
- R3: When `transOn` is 0, the walker returns the zero-extended virtual address with all three grants and makes no memory access.
- R4: The first PTE read is at `{rootPpn, 12'b0} + vaddr[31:22]*4`. The second is at `{ppn, 12'b0} + vaddr[21:12]*4`, where ppn comes from the first entry. PTE layout: bit0 valid, bit1 R, bit2 W, bit3 X, bit4 user, bit6 accessed, bit7 dirty, bits 31:10 PPN. A read request is held until the port accepts it.
- R5: These cases fault: an entry with valid clear; a leaf with W set and R clear; an entry with R, W and X all clear at the second level.
- R6: A user page faults if the effective privilege is not user and either the user-access control is clear or the access is a fetch. A non-user page faults unless the effective privilege is supervisor.
- R7: A first-level leaf whose PPN bits 9:0 are not all zero faults.
- R8: A load needs R, or X together with `reqMxr`. A store needs W. A fetch needs X.
- R9: On success the entry gets the accessed flag, and the dirty flag as well for a store. If this changes the entry, it is written back to the same address before `rspValid`. An unchanged entry causes no write.
- R10: A second-level leaf gives `{ppn, vaddr[11:0]}`. A first-level leaf gives `{ppn[21:10], vaddr[21:12], vaddr[11:0]}`.
- R11: Grants: read if R, or if X with `reqMxr`; execute if X; write only if W and either the access is a store or dirty was already set.
- R12: An error response on a PTE read faults. A fault reports a zero address and no grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request offered |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | 0 fetch, 1 load, 2 store |
| reqPriv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| reqMprv | input | 1 | Loads and stores use reqMpp as privilege when in machine mode |
| reqMpp | input | 2 | Previous privilege field |
| reqSum | input | 1 | Supervisor may load/store user pages |
| reqMxr | input | 1 | Execute-only pages are readable |
| transOn | input | 1 | 1 = paged translation, 0 = bare |
| rootPpn | input | 22 | Page number of the root table |
| memReqValid | output | 1 | Memory request |
| memReqReady | input | 1 | Memory accepts request |
| memReqWrite | output | 1 | 1 = write-back of a PTE, 0 = PTE read |
| memReqAddr | output | 34 | Byte address of the PTE |
| memReqWdata | output | 32 | Updated PTE for a write |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | PTE read data |
| memRspErr | input | 1 | Read failed |
| rspValid | output | 1 | Result pulse |
| rspFault | output | 1 | Translation failed |
| rspPaddr | output | 34 | Physical address |
| rspRead | output | 1 | Read granted |
| rspWrite | output | 1 | Write granted |
| rspExec | output | 1 | Execute granted |

## Verification
The bench aims at the ordering of the leaf checks:
- The two reserved encodings (W without R), which a looser decode would accept as writable pages.
- A pointer entry at the last level, which a walker that counts levels wrongly would follow a third time.
- A user page seen from supervisor with and without the user-access control, and for fetches, where a faulty privilege test either grants access to user pages or blocks it wrongly.

It checks the dirty-bit rule in two steps on the same entry. A load must not grant write and writes back only the accessed flag. A later store then sets dirty. A design that grants write too early would let later stores skip the dirty update.

It also covers:
- Modify-privilege loads against machine-mode fetches, which must ignore it.
- The superpage address merge and the misaligned-superpage fault.
- An error response on the second-level read.
- Back-pressure on the memory port.

// File: rtl/pt2_pkg.sv
package pt2_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int IDX_W      = 10;
  localparam int LEVELS     = 2;
  localparam int PTE_W      = 32;
  localparam int PTE_PPN_LSB = 10;
  localparam int PTE_BYTES_LOG = 2;
  localparam int PPN_W      = PTE_W - PTE_PPN_LSB;
  localparam int PA_W       = PPN_W + PAGE_SHIFT;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int LVL_W      = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W_BIT = 2;
  localparam int PTE_X = 3;
  localparam int PTE_U = 4;
  localparam int PTE_A = 6;
  localparam int PTE_D = 7;

  localparam logic [1:0] MODE_U = 2'd0;
  localparam logic [1:0] MODE_S = 2'd1;
  localparam logic [1:0] MODE_M = 2'd3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } access_e;

  typedef enum logic [1:0] {
    EV_FAIL,
    EV_NEXT,
    EV_LEAF,
    EV_LEAF_WB
  } evalKind_e;

  typedef struct packed {
    logic capture;
    logic descend;
    logic leaf;
    logic fail;
  } walkStrobe_t;
endpackage

// File: rtl/pt2_datapath.sv
module pt2_datapath
  import pt2_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [1:0]        reqPriv,
  input  logic              reqMprv,
  input  logic [1:0]        reqMpp,
  input  logic              reqSum,
  input  logic              reqMxr,
  input  logic              transOn,
  input  logic [PPN_W-1:0]  rootPpn,
  input  logic [PTE_W-1:0]  memRspData,
  input  logic              memRspErr,
  output logic              bypassNow,
  output evalKind_e         evalKind,
  output logic [PA_W-1:0]   memAddr,
  output logic [PTE_W-1:0]  memWdata,
  output logic              rspFault,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec
);
  logic [VA_W-1:0]  vaddrQ;
  access_e          accessQ;
  logic [1:0]       modeQ;
  logic             sumQ, mxrQ, bypassQ, faultQ;
  logic [LVL_W-1:0] levelQ;
  logic [PPN_W-1:0] baseQ;
  logic [PTE_W-1:0] pteQ;

  logic [1:0]       effMode;
  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] lvlMask [LEVELS];
  logic [PPN_W-1:0] curMask, leafPpn, rspPpn;
  logic [PTE_W-1:0] updatedPte;
  logic             pv, pr, pw, px, pu;

  // Superpage mask per level: low level*IDX_W PPN bits come from the VPN.
  for (genvar l = 0; l < LEVELS; l++) begin : g_mask
    assign lvlMask[l] = PPN_W'((64'd1 << (l * IDX_W)) - 64'd1);
  end

  assign curMask = lvlMask[levelQ];
  assign vpn     = vaddrQ[VA_W-1:PAGE_SHIFT];

  always_comb begin
    effMode = reqPriv;
    if (reqPriv == MODE_M && reqAccess != ACC_FETCH && reqMprv) effMode = reqMpp;
  end
  assign bypassNow = (effMode == MODE_M) || !transOn;

  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (levelQ == LVL_W'(l)) idx = vpn[l*IDX_W +: IDX_W];
    end
  end

  assign memAddr  = {baseQ, {PAGE_SHIFT{1'b0}}}
                  + {{(PA_W-IDX_W-PTE_BYTES_LOG){1'b0}}, idx, {PTE_BYTES_LOG{1'b0}}};
  assign memWdata = pteQ;

  // Evaluation of the returned entry, in check priority order.
  assign pv     = memRspData[PTE_V];
  assign pr     = memRspData[PTE_R];
  assign pw     = memRspData[PTE_W_BIT];
  assign px     = memRspData[PTE_X];
  assign pu     = memRspData[PTE_U];
  assign rspPpn = memRspData[PTE_W-1:PTE_PPN_LSB];

  always_comb begin
    updatedPte = memRspData;
    updatedPte[PTE_A] = 1'b1;
    if (accessQ == ACC_STORE) updatedPte[PTE_D] = 1'b1;
    evalKind = EV_FAIL;
    if (memRspErr || !pv)                                          evalKind = EV_FAIL;
    else if (!pr && !pw && !px)                                    evalKind = (levelQ == '0) ? EV_FAIL : EV_NEXT;
    else if (pw && !pr)                                            evalKind = EV_FAIL;
    else if (pu && modeQ != MODE_U && (!sumQ || accessQ == ACC_FETCH)) evalKind = EV_FAIL;
    else if (!pu && modeQ != MODE_S)                               evalKind = EV_FAIL;
    else if ((rspPpn & curMask) != '0)                             evalKind = EV_FAIL;
    else if (accessQ == ACC_LOAD && !(pr || (px && mxrQ)))         evalKind = EV_FAIL;
    else if (accessQ == ACC_STORE && !pw)                          evalKind = EV_FAIL;
    else if (accessQ == ACC_FETCH && !px)                          evalKind = EV_FAIL;
    else evalKind = (updatedPte != memRspData) ? EV_LEAF_WB : EV_LEAF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ  <= '0;
      accessQ <= ACC_FETCH;
      modeQ   <= MODE_U;
      sumQ    <= 1'b0;
      mxrQ    <= 1'b0;
      bypassQ <= 1'b0;
      faultQ  <= 1'b0;
      levelQ  <= '0;
      baseQ   <= '0;
      pteQ    <= '0;
    end else begin
      if (strobe.capture) begin
        vaddrQ  <= reqVaddr;
        accessQ <= access_e'(reqAccess);
        modeQ   <= effMode;
        sumQ    <= reqSum;
        mxrQ    <= reqMxr;
        bypassQ <= bypassNow;
        faultQ  <= 1'b0;
        levelQ  <= LVL_W'(LEVELS - 1);
        baseQ   <= rootPpn;
        pteQ    <= '0;
      end
      if (strobe.descend) begin
        baseQ  <= rspPpn;
        levelQ <= levelQ - 1'b1;
      end
      if (strobe.leaf) pteQ <= updatedPte;
      if (strobe.fail) faultQ <= 1'b1;
    end
  end

  assign leafPpn  = (pteQ[PTE_W-1:PTE_PPN_LSB] & ~curMask)
                  | ({{(PPN_W-VPN_W){1'b0}}, vpn} & curMask);
  assign rspFault = faultQ;
  assign rspPaddr = bypassQ ? {{(PA_W-VA_W){1'b0}}, vaddrQ}
                  : (faultQ ? '0 : {leafPpn, vaddrQ[PAGE_SHIFT-1:0]});
  assign rspRead  = bypassQ || (!faultQ && (pteQ[PTE_R] || (pteQ[PTE_X] && mxrQ)));
  assign rspExec  = bypassQ || (!faultQ && pteQ[PTE_X]);
  assign rspWrite = bypassQ || (!faultQ && pteQ[PTE_W_BIT]
                                && (accessQ == ACC_STORE || pteQ[PTE_D]));

  // R5: control never follows a pointer below the last level.
  assert_descend_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.descend |-> levelQ != '0);

  // R9: a latched leaf carries accessed, and dirty for stores.
  assert_leaf_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.leaf |=> pteQ[PTE_A] && (accessQ != ACC_STORE || pteQ[PTE_D]));
endmodule

// File: rtl/pt2_ctrl.sv
module pt2_ctrl
  import pt2_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        bypassNow,
  input  evalKind_e   evalKind,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic        rspValid,
  output walkStrobe_t strobe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ_PTE, ST_WAIT_PTE, ST_WRITE_PTE, ST_DONE
  } walkState_e;

  walkState_e state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    rspValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext = bypassNow ? ST_DONE : ST_READ_PTE;
        end
      end
      ST_READ_PTE: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_WAIT_PTE;
      end
      ST_WAIT_PTE: begin
        if (memRspValid) begin
          unique case (evalKind)
            EV_NEXT:    begin strobe.descend = 1'b1; stateNext = ST_READ_PTE;  end
            EV_LEAF:    begin strobe.leaf    = 1'b1; stateNext = ST_DONE;      end
            EV_LEAF_WB: begin strobe.leaf    = 1'b1; stateNext = ST_WRITE_PTE; end
            default:    begin strobe.fail    = 1'b1; stateNext = ST_DONE;      end
          endcase
        end
      end
      ST_WRITE_PTE: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) stateNext = ST_DONE;
      end
      ST_DONE: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R1: the result is a single-cycle pulse.
  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R1: after taking a request the walker is busy.
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);
endmodule

// File: rtl/pt2_walker.sv
module pt2_walker
  import pt2_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [1:0]        reqPriv,
  input  logic              reqMprv,
  input  logic [1:0]        reqMpp,
  input  logic              reqSum,
  input  logic              reqMxr,
  input  logic              transOn,
  input  logic [21:0]       rootPpn,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [33:0]       memReqAddr,
  output logic [31:0]       memReqWdata,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  input  logic              memRspErr,
  output logic              rspValid,
  output logic              rspFault,
  output logic [33:0]       rspPaddr,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec
);
  walkStrobe_t strobe;
  evalKind_e   evalKind;
  logic        bypassNow;

  pt2_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .bypassNow   (bypassNow),
    .evalKind    (evalKind),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  pt2_datapath u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqAccess  (reqAccess),
    .reqPriv    (reqPriv),
    .reqMprv    (reqMprv),
    .reqMpp     (reqMpp),
    .reqSum     (reqSum),
    .reqMxr     (reqMxr),
    .transOn    (transOn),
    .rootPpn    (rootPpn),
    .memRspData (memRspData),
    .memRspErr  (memRspErr),
    .bypassNow  (bypassNow),
    .evalKind   (evalKind),
    .memAddr    (memReqAddr),
    .memWdata   (memReqWdata),
    .rspFault   (rspFault),
    .rspPaddr   (rspPaddr),
    .rspRead    (rspRead),
    .rspWrite   (rspWrite),
    .rspExec    (rspExec)
  );

  // R4: a stalled memory request keeps its address and direction.
  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  // R9: every write-back carries the accessed flag.
  assert_wb_accessed_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> memReqWdata[PTE_A]);
endmodule

// File: tb/sim_pt2_walker.sv
module sim_pt2_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        reqValid = 1'b0, reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0, reqPriv = '0, reqMpp = '0;
  logic        reqMprv = 1'b0, reqSum = 1'b0, reqMxr = 1'b0, transOn = 1'b1;
  logic [21:0] rootPpn = 22'h00100;
  logic        memReqValid, memReqReady, memReqWrite;
  logic [33:0] memReqAddr;
  logic [31:0] memReqWdata;
  logic        memRspValid = 1'b0, memRspErr = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid, rspFault, rspRead, rspWrite, rspExec;
  logic [33:0] rspPaddr;

  pt2_walker u0 (.*);

  localparam logic [33:0] ERR_ADDR = 34'h0210000;
  logic [31:0] mem [logic [33:0]];
  logic [7:0]  readyTick = '0;
  int rdCount = 0, wrCount = 0;
  logic [31:0] lastWd = '0;
  int nChecks = 0, nFail = 0;

  assign memReqReady = (readyTick[1:0] != 2'd0);

  always @(posedge clk) begin
    readyTick   <= readyTick + 8'd1;
    memRspValid <= 1'b0;
    memRspErr   <= 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      if (memReqWrite) begin
        mem[memReqAddr] = memReqWdata;
        wrCount <= wrCount + 1;
        lastWd  <= memReqWdata;
      end else begin
        memRspValid <= 1'b1;
        memRspData  <= mem.exists(memReqAddr) ? mem[memReqAddr] : 32'h0;
        memRspErr   <= (memReqAddr == ERR_ADDR);
        rdCount     <= rdCount + 1;
      end
    end
  end

  typedef struct packed {
    logic        fault;
    logic [33:0] pa;
    logic [2:0]  perm;
    logic [31:0] rdExp;
    logic [31:0] wrExp;
    logic [31:0] wd;
    logic [31:0] rdBase;
    logic [31:0] wrBase;
  } exp_t;
  exp_t  expQ [$];
  string tagQ [$];

  task automatic check(string t, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  // Monitor: pops expected results as the walker produces them.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check("R1", "unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, "fault", 64'(rspFault), 64'(e.fault));
        check(t, "paddr", 64'(rspPaddr), 64'(e.pa));
        check(t, "perm rwx", 64'({rspRead, rspWrite, rspExec}), 64'(e.perm));
        check(t, "pte reads", 64'(rdCount - int'(e.rdBase)), 64'(e.rdExp));
        check(t, "pte writes", 64'(wrCount - int'(e.wrBase)), 64'(e.wrExp));
        if (e.wrExp != 0) check(t, "written pte", 64'(lastWd), 64'(e.wd));
      end
    end
  end

  task automatic setCtx(logic [1:0] priv, logic sum, logic mxr, logic mprv,
                        logic [1:0] mpp, logic tr);
    @(negedge clk);
    reqPriv = priv; reqSum = sum; reqMxr = mxr; reqMprv = mprv; reqMpp = mpp; transOn = tr;
  endtask

  // Driver: pushes the expected item, then performs the handshake.
  task automatic issue(string t, logic [31:0] va, logic [1:0] acc, logic f,
                       logic [33:0] pa, logic [2:0] perm, int rd, int wr, logic [31:0] wd);
    exp_t e;
    e.fault = f; e.pa = pa; e.perm = perm; e.rdExp = 32'(rd); e.wrExp = 32'(wr);
    e.wd = wd; e.rdBase = 32'(rdCount); e.wrBase = 32'(wrCount);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    reqVaddr = va; reqAccess = acc; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
  endtask

  localparam logic [1:0] F = 2'd0, L = 2'd1, S = 2'd2;

  initial begin
    // Root table at 0x100000, second-level table at 0x200000.
    mem[34'h0100004] = 32'h0008_0001;  // pointer to 0x200
    mem[34'h0100008] = 32'h0010_00CF;  // aligned superpage ppn 0x400
    mem[34'h010000C] = 32'h0010_04CF;  // misaligned superpage ppn 0x401
    mem[34'h0100010] = 32'h0008_4001;  // pointer to 0x210 (error region)
    mem[34'h0200000] = 32'h048D_14CF;  // ppn 0x12345 RWX A D
    mem[34'h0200004] = 32'h001D_DC03;  // ppn 0x777 R only
    mem[34'h0200008] = 32'h0022_2007;  // ppn 0x888 RW
    mem[34'h020000C] = 32'h0026_6405;  // W only
    mem[34'h0200010] = 32'h002A_A85B;  // user page R X A
    mem[34'h0200014] = 32'h002E_EC49;  // X only A
    mem[34'h020001C] = 32'h000C_0001;  // pointer at last level
    mem[34'h0200020] = 32'h0026_640D;  // W and X
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset reqReady", 64'(reqReady), 64'd1);
    check("R1", "reset rspValid", 64'(rspValid), 64'd0);
    check("R4", "reset memReqValid", 64'(memReqValid), 64'd0);

    setCtx(2'd3, 0, 0, 0, 2'd0, 1);
    issue("R2", 32'hDEADBEEF, L, 0, 34'h0DEADBEEF, 3'b111, 0, 0, 0);
    setCtx(2'd3, 0, 0, 1, 2'd1, 1);
    issue("R2", 32'h00400010, L, 0, 34'h012345010, 3'b111, 2, 0, 0);
    setCtx(2'd3, 0, 0, 1, 2'd0, 1);
    issue("R2", 32'h00400000, F, 0, 34'h000400000, 3'b111, 0, 0, 0);
    setCtx(2'd1, 0, 0, 0, 2'd0, 0);
    issue("R3", 32'h12345678, S, 0, 34'h012345678, 3'b111, 0, 0, 0);

    setCtx(2'd1, 0, 0, 0, 2'd0, 1);
    issue("R4", 32'h00400123, L, 0, 34'h012345123, 3'b111, 2, 0, 0);
    issue("R9", 32'h00401004, L, 0, 34'h000777004, 3'b100, 2, 1, 32'h001DDC43);
    issue("R9", 32'h00401008, L, 0, 34'h000777008, 3'b100, 2, 0, 0);
    issue("R11", 32'h00402000, L, 0, 34'h000888000, 3'b100, 2, 1, 32'h00222047);
    issue("R11", 32'h00402010, S, 0, 34'h000888010, 3'b110, 2, 1, 32'h002220C7);
    issue("R8", 32'h00401000, S, 1, 34'h0, 3'b000, 2, 0, 0);
    issue("R8", 32'h00402000, F, 1, 34'h0, 3'b000, 2, 0, 0);
    issue("R5", 32'h00403000, L, 1, 34'h0, 3'b000, 2, 0, 0);
    issue("R5", 32'h00408000, L, 1, 34'h0, 3'b000, 2, 0, 0);
    issue("R5", 32'h00406000, L, 1, 34'h0, 3'b000, 2, 0, 0);
    issue("R5", 32'h00407000, L, 1, 34'h0, 3'b000, 2, 0, 0);

    issue("R6", 32'h00404000, L, 1, 34'h0, 3'b000, 2, 0, 0);
    setCtx(2'd1, 1, 0, 0, 2'd0, 1);
    issue("R6", 32'h00404040, L, 0, 34'h000AAA040, 3'b101, 2, 0, 0);
    issue("R6", 32'h00404000, F, 1, 34'h0, 3'b000, 2, 0, 0);
    setCtx(2'd0, 0, 0, 0, 2'd0, 1);
    issue("R6", 32'h00404000, F, 0, 34'h000AAA000, 3'b101, 2, 0, 0);
    issue("R6", 32'h00400000, L, 1, 34'h0, 3'b000, 2, 0, 0);

    setCtx(2'd1, 0, 0, 0, 2'd0, 1);
    issue("R8", 32'h00405000, L, 1, 34'h0, 3'b000, 2, 0, 0);
    setCtx(2'd1, 0, 1, 0, 2'd0, 1);
    issue("R11", 32'h00405000, L, 0, 34'h000BBB000, 3'b101, 2, 0, 0);
    setCtx(2'd1, 0, 0, 0, 2'd0, 1);
    issue("R10", 32'h00955ABC, L, 0, 34'h000555ABC, 3'b111, 1, 0, 0);
    issue("R7", 32'h00C00000, L, 1, 34'h0, 3'b000, 1, 0, 0);
    issue("R12", 32'h01000000, L, 1, 34'h0, 3'b000, 2, 0, 0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R1 watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule